// File: doc/BRIEF.md
# Selectable Clock-Rate Enable Generator

This block produces the timing strobes of a small microcontroller core as clock enables on one fast clock. The clock runs at four times the crystal rate, so it stands for the fastest multiplied rate. Three sources can drive the system-clock strobe: a multiplied path (times 4 or times 2), the plain crystal rate, or the crystal rate divided by 256. A fixed divide-by-4 stage follows, and its output is the machine-cycle strobe. The resulting ratios are 1, 2, 4 or 1024 crystal clocks per machine cycle.

Peripherals and timers use the system-clock strobe `sys_en`. The CPU uses the machine-cycle strobe `mc_en`. A 2-bit status reports which source is in effect. A change to the selects is held back until the current machine cycle ends, so no machine cycle is ever cut short or stretched.

Top module: `clk_rate_en`

## Requirements
- R1: `rst` is a synchronous, active-high reset. While it is held, `sys_en` and `mc_en` are low and `src_stat` reads 2'b10 (direct). Number the first rising edge that samples `rst` low as edge 1. `sys_en` is then high after edges 3, 7, 11 and 15, and the first `mc_en` is high after edge 15.
- R2: Each machine cycle holds exactly four `sys_en` pulses. `mc_en` is high in the same cycle as the fourth of them.
- R3: `mc_en` is only high when `sys_en` is also high. Each strobe pulse lasts one clock cycle.
- R4: With `div_sel`=00, `mul_en`=1 and `mul_x4`=1, `sys_en` is high in every cycle. `mc_en` repeats every 4 cycles and `src_stat` is 2'b01 (multiplied).
- R5: With `div_sel`=00, `mul_en`=1 and `mul_x4`=0, `sys_en` repeats every 2 cycles. `mc_en` repeats every 8 cycles and `src_stat` is 2'b01.
- R6: With `div_sel`=00 and `mul_en`=0, the block falls back to the direct rate. `sys_en` repeats every 4 cycles, `mc_en` every 16 cycles, and `src_stat` is 2'b10.
- R7: `div_sel`=10 selects the direct rate (`mc_en` every 16 cycles, `src_stat` 2'b10). The reserved code `div_sel`=01 behaves exactly like 10.
- R8: `div_sel`=11 selects the divided source. `sys_en` repeats every 1024 cycles, `mc_en` every 4096 cycles, and `src_stat` is 2'b11.
- R9: A new select value is sampled only on the edge that ends a machine cycle (the edge after a cycle with `mc_en` high). The machine cycle running when the change arrives keeps its full old length. The first machine cycle after the switch has the full new length.
- R10: `mul_x4` has no effect unless `div_sel`=00 and `mul_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the crystal rate |
| rst | input | 1 | Synchronous active-high reset |
| mul_en | input | 1 | Enables the multiplied source |
| mul_x4 | input | 1 | 1: times 4, 0: times 2 (multiplied source only) |
| div_sel | input | 2 | Source select: 00 multiplied, 01/10 direct, 11 divided by 256 |
| sys_en | output | 1 | One-cycle system-clock enable strobe |
| mc_en | output | 1 | One-cycle machine-cycle enable strobe |
| src_stat | output | 2 | Source in effect: 01 multiplied, 10 direct, 11 divided |

## Verification
Two events can fall in the same cycle: a select change and the end of a machine cycle. The bench provokes this by driving new selects in the very cycle where `mc_en` is high. It expects the switch on the next edge and a full-length first machine cycle in the new mode. A second case drives the change in the middle of a direct-rate machine cycle. There the bench expects `src_stat` to hold every cycle and the old cycle to keep all 16 clocks. Every `mc_en` also coincides with a `sys_en`, so the checker counts system strobes between machine strobes and requires four.

// File: rtl/clk_rate_en.sv
module clk_rate_en #(
  parameter int SLOW_DIV = 256,
  parameter int MC_DIV   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mul_en,
  input  logic       mul_x4,
  input  logic [1:0] div_sel,
  output logic       sys_en,
  output logic       mc_en,
  output logic [1:0] src_stat
);
  localparam int XTAL_DIV = 4;
  localparam int CNT_W    = $clog2(XTAL_DIV * SLOW_DIV);
  localparam int PH_W     = $clog2(MC_DIV);

  localparam logic [1:0] M_X4  = 2'd0;
  localparam logic [1:0] M_X2  = 2'd1;
  localparam logic [1:0] M_DIR = 2'd2;
  localparam logic [1:0] M_DIV = 2'd3;

  logic [1:0]       mode_q, mode_d;
  logic [CNT_W-1:0] tick_cnt, tick_last;
  logic [PH_W-1:0]  phase;

  always_comb begin
    case (div_sel)
      2'b00:   mode_d = !mul_en ? M_DIR : (mul_x4 ? M_X4 : M_X2);
      2'b11:   mode_d = M_DIV;
      default: mode_d = M_DIR;
    endcase
  end

  always_comb begin
    case (mode_q)
      M_X4:    tick_last = '0;
      M_X2:    tick_last = CNT_W'(XTAL_DIV / 2 - 1);
      M_DIR:   tick_last = CNT_W'(XTAL_DIV - 1);
      default: tick_last = CNT_W'(XTAL_DIV * SLOW_DIV - 1);
    endcase
  end

  assign sys_en   = (tick_cnt == tick_last);
  assign mc_en    = sys_en && (phase == PH_W'(MC_DIV - 1));
  assign src_stat = mode_q[1] ? mode_q : 2'b01;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_DIR;
      tick_cnt <= '0;
      phase    <= '0;
    end else if (mc_en) begin
      mode_q   <= mode_d;
      tick_cnt <= '0;
      phase    <= '0;
    end else if (sys_en) begin
      tick_cnt <= '0;
      phase    <= phase + 1'b1;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clk_rate_en_chk.sv
module clk_rate_en_chk #(
  parameter int MC_DIV = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       sys_en,
  input logic       mc_en,
  input logic [1:0] src_stat,
  input logic [1:0] mode_q
);
  logic [7:0] sys_seen;

  always_ff @(posedge clk) begin
    if (rst || mc_en) sys_seen <= '0;
    else if (sys_en)  sys_seen <= sys_seen + 1'b1;
  end

  AST_MC_WITH_SYS: assert property (@(posedge clk) disable iff (rst) mc_en |-> sys_en); // R3
  AST_FOUR_SYS: assert property (@(posedge clk) disable iff (rst) mc_en |-> sys_seen == 8'(MC_DIV - 1)); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst) !mc_en |=> $stable(src_stat)); // R9
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (src_stat == 2'b10 && !mc_en)); // R1
  AST_X4_EVERY: assert property (@(posedge clk) disable iff (rst) (mode_q == 2'd0) |-> sys_en); // R4
  AST_SLOW_GAP: assert property (@(posedge clk) disable iff (rst) (src_stat[1] && sys_en && !mc_en) |=> !sys_en); // R6
endmodule

bind clk_rate_en clk_rate_en_chk #(.MC_DIV(MC_DIV)) u_chk (
  .clk(clk), .rst(rst), .sys_en(sys_en), .mc_en(mc_en),
  .src_stat(src_stat), .mode_q(mode_q)
);

// File: tb/test_clk_rate_en.sv
`timescale 1ns/1ps
module test_clk_rate_en;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mul_en = 1'b0, mul_x4 = 1'b0;
  logic [1:0] div_sel = 2'b10;
  logic sys_en, mc_en;
  logic [1:0] src_stat;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  clk_rate_en i_clk_rate_en (
    .clk(clk), .rst(rst), .mul_en(mul_en), .mul_x4(mul_x4), .div_sel(div_sel),
    .sys_en(sys_en), .mc_en(mc_en), .src_stat(src_stat)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_mc(output int n, output int s);
    n = 0; s = 0;
    do begin
      @(negedge clk);
      n++;
      if (sys_en) s++;
    end while (!mc_en);
  endtask

  task automatic t_reset();
    int n, s;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sys_en in reset", sys_en, 0);
    check("R1 mc_en in reset", mc_en, 0);
    check("R1 status in reset", src_stat, 2);
    rst = 1'b0;
    wait_mc(n, s);
    check("R1 first mc_en edge", n, 15);
    check("R2 sys_en per machine cycle", s, 4);
  endtask

  task automatic t_mode(input string req, input logic me, input logic x4,
                        input logic [1:0] sel, input int period, input int stat);
    int n, s;
    mul_en = me; mul_x4 = x4; div_sel = sel;
    wait_mc(n, s);
    wait_mc(n, s);
    wait_mc(n, s);
    check({req, " mc period"}, n, period);
    check({req, " sys count (R2)"}, s, 4);
    check({req, " status"}, src_stat, stat);
  endtask

  task automatic t_x2_spacing();
    int gap;
    mul_en = 1'b1; mul_x4 = 1'b0; div_sel = 2'b00;
    do @(negedge clk); while (!sys_en);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sys_en);
    check("R5 sys_en spacing", gap, 2);
  endtask

  task automatic t_mid_switch();
    int n, s, bad;
    mul_en = 1'b0; mul_x4 = 1'b0; div_sel = 2'b10;
    wait_mc(n, s);
    wait_mc(n, s);
    bad = 0;
    n = 0;
    repeat (5) begin @(negedge clk); n++; if (src_stat != 2) bad++; end
    mul_en = 1'b1; mul_x4 = 1'b1; div_sel = 2'b00;
    do begin
      @(negedge clk); n++;
      if (src_stat != 2) bad++;
    end while (!mc_en);
    check("R9 old cycle length kept", n, 16);
    check("R9 status held mid cycle", bad, 0);
    wait_mc(n, s);
    check("R9 first new cycle length", n, 4);
    check("R9 status after switch", src_stat, 1);
  endtask

  task automatic t_same_cycle();
    int n, s;
    mul_en = 1'b1; mul_x4 = 1'b1; div_sel = 2'b00;
    wait_mc(n, s);
    wait_mc(n, s);
    mul_en = 1'b0; div_sel = 2'b10;
    @(negedge clk);
    check("R9 switch on boundary edge", src_stat, 2);
    n = 1;
    while (!mc_en) begin @(negedge clk); n++; end
    check("R9 boundary first cycle length", n, 16);
  endtask

  initial begin
    #(150000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_mode("R4 times-4", 1'b1, 1'b1, 2'b00, 4, 1);
    t_mode("R5 times-2", 1'b1, 1'b0, 2'b00, 8, 1);
    t_x2_spacing();
    t_mode("R6 fallback", 1'b0, 1'b1, 2'b00, 16, 2);
    t_mode("R7 code 10", 1'b0, 1'b0, 2'b10, 16, 2);
    t_mode("R7 code 01", 1'b1, 1'b1, 2'b01, 16, 2);
    t_mode("R10 x4 ignored direct", 1'b1, 1'b1, 2'b10, 16, 2);
    t_mode("R8 divided", 1'b0, 1'b0, 2'b11, 4096, 3);
    t_mode("R10 x4 ignored divided", 1'b1, 1'b1, 2'b11, 4096, 3);
    t_mid_switch();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule